// File: doc/BRIEF.md
# Partial-Write Merge and Longword Coalescing Unit

This block connects a 32-bit requester to a memory port that only transfers whole 64-bit quadwords. The requester issues reads and writes with a byte address and four byte enables. The memory side only ever sees full quadword reads and full quadword writes. It uses a request/grant handshake, and read data comes back later with a valid strobe.

A write of fewer than four bytes becomes a hidden read-modify-write. The block reads the containing quadword, replaces only the enabled bytes, and writes all eight bytes back. A full longword write is parked in a one-entry holding register. If the next request is a full longword to the other half of the same quadword, the two halves go out as one quadword write with no read. If a different request arrives first, or the holding register sits idle for `IDLE_LIMIT` cycles, the parked longword is flushed through the read-modify-write path. A flush caused by a request is followed by a replay of that request.

The controller has six states:
- `ST_IDLE` accepts requests.
- `ST_RD_ISSUE` requests a quadword read.
- `ST_RD_WAIT` waits for read data.
- `ST_WR_ISSUE` requests a quadword write.
- `ST_RESPOND` returns read data.
- `ST_REPLAY` processes a request that was stashed during a flush.

Its transitions are:
- accept-partial: IDLE to RD_ISSUE.
- accept-pair: IDLE to WR_ISSUE.
- accept-mismatch: IDLE to RD_ISSUE, with the request stashed.
- timeout: IDLE to RD_ISSUE.
- read-granted: RD_ISSUE to RD_WAIT.
- data-back: RD_WAIT to WR_ISSUE for a merge, or to RESPOND for a read.
- write-granted: WR_ISSUE to REPLAY when a request is stashed, otherwise to IDLE.
- respond-done: RESPOND to IDLE.
- replay-park: REPLAY to IDLE.
- replay-issue: REPLAY to RD_ISSUE.

Top module: `wmerge_unit`

## Requirements
- R1: After reset, `req_ready` is 1, and `mem_req` and `rsp_valid` are 0.
- R2: A write whose enables are not all four ones causes exactly one quadword read and then one quadword write. The write changes only the enabled bytes, which may be non-contiguous. Enable bit i selects byte i of the longword (little-endian). When `req_addr[2]` is 1, that byte lands at quadword byte i+4; otherwise it lands at byte i.
- R3: A full longword write (enables 4'b1111) followed directly by a full longword write to the other half of the same quadword produces one write of {upper, lower} and no read.
- R4: A parked longword with no further request is flushed by read-modify-write. The flush read request appears on the memory port right after the eighth clock edge that follows the accepting edge, and not earlier.
- R5: A request that does not complete a pair while a longword is parked first flushes the parked longword, then executes the request.
- R6: A read of a quadword whose half is parked returns the parked data.
- R7: A read returns the 32-bit half selected by `req_addr[2]`. `rsp_valid` is a one-cycle pulse in the cycle after `mem_rvalid` is sampled.
- R8: `req_ready` is 0 whenever the memory port is busy; only one request is in flight.
- R9: `mem_addr` equals `req_addr[17:3]`. A memory request, with its address and data, holds steady until `mem_gnt`.
- R10: Two full longword writes to the same half of one quadword are not coalesced. The first is flushed by read-modify-write and the second is parked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Requester command valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Byte address |
| req_be | input | 4 | Byte enables of the longword |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Command accepted on this edge when valid |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 32 | Read data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 15 | Quadword address |
| mem_wdata | output | 64 | Quadword write data |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | 64 | Memory read data |

## Verification
The bench uses sparse enable patterns such as 0101 and 1001, which expose a merge that ignores the enables or shifts them into the wrong half. It uses back-to-back halves in both orders, which catch a unit that issues a needless read or swaps the halves. It writes the same half twice, which would silently lose the first longword if coalesced. It times the idle flush to the exact edge, which catches an off-by-one timeout. It reads a quadword with a parked half, which would return stale memory if the flush were skipped. It also stalls the memory grant, which a unit that drops or changes its request would fail.

// File: rtl/wmerge_pkg.sv
package wmerge_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ISSUE,
        ST_RD_WAIT,
        ST_WR_ISSUE,
        ST_RESPOND,
        ST_REPLAY
    } wm_state_t;

    typedef enum logic [1:0] {
        JOB_READ,
        JOB_MERGE,
        JOB_FULL
    } wm_job_t;

endpackage

// File: rtl/wmerge_lane_merge.sv
module wmerge_lane_merge #(
    parameter int LANES = 8
) (
    input  logic [LANES*8-1:0] old_data,
    input  logic [LANES*8-1:0] new_data,
    input  logic [LANES-1:0]   lane_en,
    output logic [LANES*8-1:0] merged
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[g*8 +: 8] = lane_en[g] ? new_data[g*8 +: 8] : old_data[g*8 +: 8];
    end
endmodule

// File: rtl/wmerge_hold.sv
module wmerge_hold #(
    parameter int QADDR_W    = 15,
    parameter int IDLE_LIMIT = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               clear,
    input  logic               tick,
    input  logic [QADDR_W-1:0] in_qaddr,
    input  logic               in_upper,
    input  logic [31:0]        in_data,
    output logic               valid,
    output logic [QADDR_W-1:0] qaddr,
    output logic               upper,
    output logic [31:0]        data,
    output logic               expired
);
    localparam int TMR_W = $clog2(IDLE_LIMIT + 1);
    localparam logic [TMR_W-1:0] LAST = TMR_W'(IDLE_LIMIT - 1);

    logic [TMR_W-1:0] idle_cnt;

    assign expired = valid && tick && (idle_cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid    <= 1'b0;
            qaddr    <= '0;
            upper    <= 1'b0;
            data     <= '0;
            idle_cnt <= '0;
        end else if (load) begin
            valid    <= 1'b1;
            qaddr    <= in_qaddr;
            upper    <= in_upper;
            data     <= in_data;
            idle_cnt <= '0;
        end else begin
            if (clear) valid <= 1'b0;
            if (!tick || !valid)     idle_cnt <= '0;
            else if (idle_cnt != LAST) idle_cnt <= idle_cnt + 1'b1;
        end
    end

    assert_timeout_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
        expired |=> !valid);

endmodule

// File: rtl/wmerge_unit.sv
module wmerge_unit
    import wmerge_pkg::*;
#(
    parameter int QADDR_W    = 15,
    parameter int IDLE_LIMIT = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [QADDR_W+2:0]   req_addr,
    input  logic [3:0]           req_be,
    input  logic [31:0]          req_wdata,
    output logic                 req_ready,
    output logic                 rsp_valid,
    output logic [31:0]          rsp_rdata,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [QADDR_W-1:0]   mem_addr,
    output logic [63:0]          mem_wdata,
    input  logic                 mem_gnt,
    input  logic                 mem_rvalid,
    input  logic [63:0]          mem_rdata
);
    localparam int ADDR_W = QADDR_W + 3;
    localparam int LANES  = 8;

    wm_state_t state, state_nx;

    // job registers
    wm_job_t            job;
    logic [QADDR_W-1:0] job_qaddr;
    logic [LANES-1:0]   job_be;
    logic [63:0]        job_data;
    logic               job_upper;
    logic [31:0]        rsp_data;

    // stashed request
    logic               pend_v;
    logic               pend_wr;
    logic [ADDR_W-1:0]  pend_addr;
    logic [3:0]         pend_be;
    logic [31:0]        pend_data;

    // request source (bus in IDLE, stash in REPLAY)
    logic               src_wr;
    logic [ADDR_W-1:0]  src_addr;
    logic [3:0]         src_be;
    logic [31:0]        src_data;
    logic [QADDR_W-1:0] src_qaddr;
    logic               src_upper;
    logic               src_full;
    logic [LANES-1:0]   src_be8;
    logic               pair_hit;

    // holding register
    logic               hold_load, hold_clear, hold_tick;
    logic               hold_valid, hold_upper, hold_expired;
    logic [QADDR_W-1:0] hold_qaddr;
    logic [31:0]        hold_data;

    // control strobes
    logic job_ld_src, job_ld_hold, job_ld_pair, pend_ld, pend_clr;
    logic [63:0] merged;

    always_comb begin
        if (state == ST_REPLAY) begin
            src_wr   = pend_wr;
            src_addr = pend_addr;
            src_be   = pend_be;
            src_data = pend_data;
        end else begin
            src_wr   = req_write;
            src_addr = req_addr;
            src_be   = req_be;
            src_data = req_wdata;
        end
    end

    assign src_qaddr = src_addr[ADDR_W-1:3];
    assign src_upper = src_addr[2];
    assign src_full  = src_wr && (src_be == 4'hF);
    assign src_be8   = src_upper ? {src_be, 4'h0} : {4'h0, src_be};
    assign pair_hit  = hold_valid && src_full && (hold_qaddr == src_qaddr)
                       && (hold_upper != src_upper);
    assign hold_tick = (state == ST_IDLE) && !req_valid;

    wmerge_hold #(.QADDR_W(QADDR_W), .IDLE_LIMIT(IDLE_LIMIT)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (hold_load),
        .clear    (hold_clear),
        .tick     (hold_tick),
        .in_qaddr (src_qaddr),
        .in_upper (src_upper),
        .in_data  (src_data),
        .valid    (hold_valid),
        .qaddr    (hold_qaddr),
        .upper    (hold_upper),
        .data     (hold_data),
        .expired  (hold_expired)
    );

    wmerge_lane_merge #(.LANES(LANES)) u_merge (
        .old_data (mem_rdata),
        .new_data (job_data),
        .lane_en  (job_be),
        .merged   (merged)
    );

    // next state and strobes
    always_comb begin
        state_nx    = state;
        hold_load   = 1'b0;
        hold_clear  = 1'b0;
        job_ld_src  = 1'b0;
        job_ld_hold = 1'b0;
        job_ld_pair = 1'b0;
        pend_ld     = 1'b0;
        pend_clr    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (hold_valid) begin
                        hold_clear = 1'b1;
                        if (pair_hit) begin
                            job_ld_pair = 1'b1;
                            state_nx    = ST_WR_ISSUE;
                        end else begin
                            job_ld_hold = 1'b1;
                            pend_ld     = 1'b1;
                            state_nx    = ST_RD_ISSUE;
                        end
                    end else if (src_full) begin
                        hold_load = 1'b1;
                    end else begin
                        job_ld_src = 1'b1;
                        state_nx   = ST_RD_ISSUE;
                    end
                end else if (hold_expired) begin
                    hold_clear  = 1'b1;
                    job_ld_hold = 1'b1;
                    state_nx    = ST_RD_ISSUE;
                end
            end
            ST_REPLAY: begin
                pend_clr = 1'b1;
                if (src_full) begin
                    hold_load = 1'b1;
                    state_nx  = ST_IDLE;
                end else begin
                    job_ld_src = 1'b1;
                    state_nx   = ST_RD_ISSUE;
                end
            end
            ST_RD_ISSUE: if (mem_gnt) state_nx = ST_RD_WAIT;
            ST_RD_WAIT: begin
                if (mem_rvalid) state_nx = (job == JOB_READ) ? ST_RESPOND : ST_WR_ISSUE;
            end
            ST_WR_ISSUE: begin
                if (mem_gnt) state_nx = pend_v ? ST_REPLAY : ST_IDLE;
            end
            ST_RESPOND: state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // job, stash and response registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            job       <= JOB_READ;
            job_qaddr <= '0;
            job_be    <= '0;
            job_data  <= '0;
            job_upper <= 1'b0;
            rsp_data  <= '0;
            pend_v    <= 1'b0;
            pend_wr   <= 1'b0;
            pend_addr <= '0;
            pend_be   <= '0;
            pend_data <= '0;
        end else begin
            if (job_ld_pair) begin
                job       <= JOB_FULL;
                job_qaddr <= src_qaddr;
                job_be    <= '1;
                job_data  <= src_upper ? {src_data, hold_data} : {hold_data, src_data};
            end else if (job_ld_hold) begin
                job       <= JOB_MERGE;
                job_qaddr <= hold_qaddr;
                job_be    <= hold_upper ? 8'hF0 : 8'h0F;
                job_data  <= {hold_data, hold_data};
            end else if (job_ld_src) begin
                job       <= src_wr ? JOB_MERGE : JOB_READ;
                job_qaddr <= src_qaddr;
                job_be    <= src_be8;
                job_data  <= {src_data, src_data};
                job_upper <= src_upper;
            end else if (state == ST_RD_WAIT && mem_rvalid) begin
                if (job == JOB_READ)
                    rsp_data <= job_upper ? mem_rdata[63:32] : mem_rdata[31:0];
                else
                    job_data <= merged;
            end
            if (pend_ld) begin
                pend_v    <= 1'b1;
                pend_wr   <= req_write;
                pend_addr <= req_addr;
                pend_be   <= req_be;
                pend_data <= req_wdata;
            end else if (pend_clr) begin
                pend_v <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready = (state == ST_IDLE);
        mem_req   = (state == ST_RD_ISSUE) || (state == ST_WR_ISSUE);
        mem_we    = (state == ST_WR_ISSUE);
        mem_addr  = job_qaddr;
        mem_wdata = job_data;
        rsp_valid = (state == ST_RESPOND);
        rsp_rdata = rsp_data;
    end

    assert_req_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));

    assert_rsp_after_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(mem_rvalid));

    assert_rsp_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);

endmodule

// File: tb/sim_wmerge_unit.sv
module sim_wmerge_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, rsp_valid, mem_req, mem_we;
    logic [31:0] rsp_rdata;
    logic [14:0] mem_addr;
    logic [63:0] mem_wdata;
    logic        mem_gnt = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [63:0] mem_rdata = '0;

    always #5 clk = ~clk;

    wmerge_unit u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_be(req_be), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata)
    );

    localparam logic [63:0] INIT_Q = 64'hF0E1D2C3B4A59687;

    int n_vec = 0;
    int n_bad = 0;
    int n_rd  = 0;
    int n_wr  = 0;
    bit stall = 1'b0;
    bit done  = 1'b0;
    logic [63:0] mem_q [16];

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // memory model
    initial begin
        bit rd_stage = 1'b0;
        logic [63:0] rd_buf = '0;
        for (int i = 0; i < 16; i++) mem_q[i] = INIT_Q;
        forever begin
            @(negedge clk);
            mem_rvalid = rd_stage;
            mem_rdata  = rd_buf;
            rd_stage   = 1'b0;
            mem_gnt    = mem_req && !stall;
            if (mem_gnt) begin
                if (mem_we) begin
                    mem_q[mem_addr[3:0]] = mem_wdata;
                    n_wr++;
                end else begin
                    rd_stage = 1'b1;
                    rd_buf   = mem_q[mem_addr[3:0]];
                    n_rd++;
                end
            end
        end
    end

    // R7 response timing monitor
    initial begin
        bit last_rv = 1'b0;
        forever begin
            @(posedge clk);
            if (rsp_valid) check("R7 rsp one cycle after rvalid", 64'(last_rv), 64'd1);
            last_rv = mem_rvalid;
        end
    end

    task automatic issue(input bit wr, input logic [17:0] a, input logic [3:0] be,
                         input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic read_word(input logic [17:0] a, output logic [31:0] d);
        issue(1'b0, a, 4'h0, 32'h0);
        while (!rsp_valid) @(negedge clk);
        d = rsp_rdata;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
        while (!req_ready || mem_req) @(negedge clk);
    endtask

    // vector table: write flag, address, enables, data, expected read value
    typedef struct packed {
        logic        wr;
        logic [17:0] addr;
        logic [3:0]  be;
        logic [31:0] data;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VT [NV] = '{
        '{1'b1, 18'h00000, 4'b0101, 32'h11223344, 32'h0},          // R2 sparse low half
        '{1'b0, 18'h00000, 4'h0,    32'h0,        32'hB4229644},   // R2 R7
        '{1'b0, 18'h00004, 4'h0,    32'h0,        32'hF0E1D2C3},   // R2 untouched half
        '{1'b1, 18'h0000C, 4'b1000, 32'hAABBCCDD, 32'h0},          // R2 top byte
        '{1'b0, 18'h0000C, 4'h0,    32'h0,        32'hAAE1D2C3},   // R2 R7
        '{1'b1, 18'h00010, 4'b0110, 32'h55667788, 32'h0},          // R2 middle bytes
        '{1'b0, 18'h00010, 4'h0,    32'h0,        32'hB4667787},   // R2
        '{1'b1, 18'h00018, 4'hF,    32'h01020304, 32'h0},          // R3 low half
        '{1'b1, 18'h0001C, 4'hF,    32'h05060708, 32'h0},          // R3 high half
        '{1'b0, 18'h00018, 4'h0,    32'h0,        32'h01020304},   // R3
        '{1'b0, 18'h0001C, 4'h0,    32'h0,        32'h05060708}    // R3
    };

    initial begin
        logic [31:0] rd;
        int r0, w0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", 64'(req_ready), 64'd1);
        check("R1 mem_req after reset", 64'(mem_req), 64'd0);
        check("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);

        for (int i = 0; i < NV; i++) begin
            if (VT[i].wr) begin
                issue(1'b1, VT[i].addr, VT[i].be, VT[i].data);
            end else begin
                read_word(VT[i].addr, rd);
                check("R2/R3/R7 table read", 64'(rd), 64'(VT[i].exp));
            end
        end
        settle();

        // R3: halves in reverse order, no read
        r0 = n_rd; w0 = n_wr;
        issue(1'b1, 18'h00024, 4'hF, 32'h89ABCDEF);
        issue(1'b1, 18'h00020, 4'hF, 32'h01234567);
        settle();
        check("R3 pair reads", 64'(n_rd - r0), 64'd0);
        check("R3 pair writes", 64'(n_wr - w0), 64'd1);
        check("R3 pair data", mem_q[4], 64'h89ABCDEF01234567);

        // R4: timeout flush edge
        r0 = n_rd; w0 = n_wr;
        issue(1'b1, 18'h00028, 4'hF, 32'hCAFEBABE);
        repeat (7) @(negedge clk);
        check("R4 no flush before limit", 64'(mem_req), 64'd0);
        @(negedge clk);
        check("R4 flush read at limit", 64'(mem_req), 64'd1);
        check("R4 flush is read", 64'(mem_we), 64'd0);
        check("R8 not ready while busy", 64'(req_ready), 64'd0);
        settle();
        check("R4 flush reads", 64'(n_rd - r0), 64'd1);
        check("R4 flush writes", 64'(n_wr - w0), 64'd1);
        check("R4 flush data", mem_q[5], 64'hF0E1D2C3CAFEBABE);

        // R10 then R5
        r0 = n_rd; w0 = n_wr;
        issue(1'b1, 18'h00030, 4'hF, 32'hDEADBEEF);
        issue(1'b1, 18'h00030, 4'hF, 32'h12345678);
        repeat (2) @(negedge clk);
        while (!req_ready) @(negedge clk);
        check("R10 same half flush reads", 64'(n_rd - r0), 64'd1);
        check("R10 same half flush writes", 64'(n_wr - w0), 64'd1);
        check("R10 first longword stored", mem_q[6], 64'hF0E1D2C3DEADBEEF);
        r0 = n_rd; w0 = n_wr;
        issue(1'b1, 18'h00034, 4'b0001, 32'h000000AA);
        settle();
        check("R5 flush plus request reads", 64'(n_rd - r0), 64'd2);
        check("R5 flush plus request writes", 64'(n_wr - w0), 64'd2);
        read_word(18'h00030, rd);
        check("R5 flushed longword", 64'(rd), 64'h12345678);
        read_word(18'h00034, rd);
        check("R5 request after flush", 64'(rd), 64'hF0E1D2AA);

        // R6: read of parked half
        issue(1'b1, 18'h0003C, 4'hF, 32'h0BADF00D);
        read_word(18'h0003C, rd);
        check("R6 read sees parked data", 64'(rd), 64'h0BADF00D);
        settle();

        // R9: stalled grant, top address
        stall = 1'b1;
        issue(1'b1, 18'h3FFF8, 4'b1001, 32'hC0FFEE11);
        while (!mem_req) @(negedge clk);
        check("R9 quadword address", 64'(mem_addr), 64'h7FFF);
        repeat (3) @(negedge clk);
        check("R9 request held under stall", 64'(mem_req), 64'd1);
        check("R9 address held under stall", 64'(mem_addr), 64'h7FFF);
        stall = 1'b0;
        settle();
        read_word(18'h3FFF8, rd);
        check("R9 R2 stalled merge result", 64'(rd), 64'hC0A59611);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule